// File: doc/BRIEF.md
# Multichannel CIC Decimator

This block is a cascaded integrator-comb decimation filter that serves several channels sharing one sample stream. Each clock cycle may carry one sample, marked by a valid flag and tagged with the index of the channel it belongs to. Channels may arrive in any order and with idle cycles between them. The block holds a private copy of every integrator register, comb delay line and decimation phase counter for each channel. It returns one full-precision result per channel for every D samples of that channel. Each result carries its own valid flag and channel tag.

The filter has N integrator stages at the input rate and N comb stages with differential delay M at the reduced rate. The output width is the input width plus N*ceil(log2(D*M)) bits, so the result is exact. Integrators wrap in two's complement. Comb arithmetic runs only on the samples that are kept, and the D-1 discarded positions per channel cost no comb work.

A debug input, bypass, replaces filtering with a plain path. Each accepted sample then produces an output. At the channel's kept position that output is the input scaled by the DC gain (D*M)^N, and at every other position it is zero. While bypass is high the filter state does not move, but the phase counters still count. Parameters with D below 2 are rejected at elaboration.

Top module: `cic_mc_decim`

## Requirements
- R1: While rst_n is low at a rising clock edge, out_vld is 0 on the following cycle. All per-channel integrator, comb and phase state returns to zero, so later results equal those of a filter that has seen no samples.
- R2: A sample is taken only in cycles with in_vld high. In cycles with in_vld low, the values on in_data and in_ch have no effect on any later output.
- R3: For each channel, the accepted samples are numbered from 0 after reset. Sample k with k mod D = D-1 makes out_vld high in the next cycle. An accepted non-bypass sample at any other position leaves out_vld low in the next cycle.
- R4: The value of the result for channel c at sample k equals y_N[k]. Here y_0 is the channel's accepted input sequence, taken as two's complement DW-bit values, with zeros before reset. y_j[i] is the sum of y_{j-1}[i-t] for t = 0 .. D*M-1.
- R5: Each channel's state is separate, whatever order and spacing the channels arrive in. out_ch in a valid output cycle equals the in_ch of the sample that produced it.
- R6: out_data is DW + N*ceil(log2(D*M)) bits, two's complement. A long run of full-scale inputs gives exactly x*(D*M)^N, with no wrap, for both the most negative and the most positive input.
- R7: With bypass high, every accepted sample makes out_vld high in the next cycle, with out_ch equal to its channel. out_data is in_data*(D*M)^N at the kept position (k mod D = D-1) and zero at every other position.
- R8: In a cycle after one with in_vld low, out_vld is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_vld | input | 1 | Input sample present this cycle |
| in_ch | input | CW = max(1, ceil(log2(NCH))) | Channel of the input sample |
| in_data | input | DW | Input sample, two's complement |
| bypass | input | 1 | Selects the gain-scaled zero-stuffed debug path |
| out_vld | output | 1 | Output result present this cycle |
| out_ch | output | CW | Channel of the output result |
| out_data | output | OW = DW + NSTG*ceil(log2(DEC*DDLY)) | Full-precision result, two's complement |

## Verification
The main test drives random samples with channels in round-robin order and random idle cycles, while garbage appears on the data and channel pins when valid is low. This pattern tells whether the per-channel phase and the moving-sum cascade stay aligned, and whether idle cycles leak into state. A second stream draws channels in random order, so one channel's state corrupting another's shows up at once. Runs of full-scale negative and positive inputs expose any shortfall in output width. An impulse after a reset taken mid-stream shows whether every channel's state was cleared. A bypass run separates the kept position from the zero-stuffed ones and checks the gain constant.

// File: rtl/cic_pkg.sv
// Package: shared helpers for the multichannel CIC decimator.
// Assumes all arguments are positive and small enough for int arithmetic.
package cic_pkg;

    // Output width: input width plus growth from N stages of D*M sums.
    function automatic int cic_out_width(int dw, int nstg, int dec, int ddly);
        return dw + nstg * $clog2(dec * ddly);
    endfunction

    // DC gain of the filter, (D*M)^N.
    function automatic int cic_gain(int dec, int ddly, int nstg);
        int g;
        g = 1;
        for (int i = 0; i < nstg; i++) g = g * dec * ddly;
        return g;
    endfunction

    // Channel index width, at least one bit.
    function automatic int cic_ch_width(int nch);
        return (nch > 1) ? $clog2(nch) : 1;
    endfunction

endpackage

// File: rtl/cic_phase_bank.sv
// Module: per-channel decimation phase counters.
// Counts accepted samples of each channel modulo DEC. "last" flags the kept
// position of the addressed channel. Assumes ch < NCH whenever adv is high.
module cic_phase_bank #(
    parameter int NCH = 4,
    parameter int DEC = 5,
    parameter int CW  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic [CW-1:0] ch,
    output logic          last
);
    localparam int PW = $clog2(DEC);

    logic [NCH-1:0][PW-1:0] ph;

    // Kept-position flag for the addressed channel.
    assign last = (ph[ch] == PW'(DEC - 1));

    // Advance the addressed channel's phase, wrapping after DEC samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph <= '0;
        end else if (adv) begin
            ph[ch] <= last ? '0 : ph[ch] + PW'(1);
        end
    end

    // Phases move only when a sample is accepted.
    assert_phase_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(ph));

endmodule

// File: rtl/cic_integ_bank.sv
// Module: per-channel integrator cascade running at the input rate.
// Holds NSTG wrapping accumulators per channel. "sum" is the updated last
// stage for the addressed channel, combinational from din and state.
// Assumes ch < NCH whenever upd is high.
module cic_integ_bank #(
    parameter int NCH  = 4,
    parameter int NSTG = 3,
    parameter int DW   = 12,
    parameter int OW   = 24,
    parameter int CW   = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd,
    input  logic [CW-1:0] ch,
    input  logic [DW-1:0] din,
    output logic [OW-1:0] sum
);
    logic [NCH-1:0][NSTG-1:0][OW-1:0] acc;
    logic [NSTG:0][OW-1:0]            nxt;

    // Ripple the sign-extended sample through the addressed channel's stages.
    always_comb begin
        nxt[0] = {{(OW - DW){din[DW-1]}}, din};
        for (int k = 0; k < NSTG; k++) begin
            nxt[k+1] = acc[ch][k] + nxt[k];
        end
    end

    assign sum = nxt[NSTG];

    // Store the new accumulator values of the addressed channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (upd) begin
            for (int k = 0; k < NSTG; k++) acc[ch][k] <= nxt[k+1];
        end
    end

    // No accumulator moves without an accepted filtering sample.
    assert_integ_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(acc));

endmodule

// File: rtl/cic_comb_bank.sv
// Module: per-channel comb cascade running at the decimated rate.
// Each stage subtracts the value it saw DDLY kept samples earlier. "dout" is
// combinational from din and the addressed channel's delay lines.
// Assumes fire is high only on kept positions and ch < NCH.
module cic_comb_bank #(
    parameter int NCH  = 4,
    parameter int NSTG = 3,
    parameter int DDLY = 2,
    parameter int OW   = 24,
    parameter int CW   = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fire,
    input  logic [CW-1:0] ch,
    input  logic [OW-1:0] din,
    output logic [OW-1:0] dout
);
    logic [NCH-1:0][NSTG-1:0][DDLY-1:0][OW-1:0] dly;
    logic [NSTG:0][OW-1:0]                      stg;

    // Differences through the stages of the addressed channel.
    always_comb begin
        stg[0] = din;
        for (int k = 0; k < NSTG; k++) begin
            stg[k+1] = stg[k] - dly[ch][k][DDLY-1];
        end
    end

    assign dout = stg[NSTG];

    // Shift each stage input into its delay line on a kept sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dly <= '0;
        end else if (fire) begin
            for (int k = 0; k < NSTG; k++) begin
                dly[ch][k][0] <= stg[k];
                for (int j = 1; j < DDLY; j++) dly[ch][k][j] <= dly[ch][k][j-1];
            end
        end
    end

    // Comb state changes only on kept samples.
    assert_comb_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> $stable(dly));

endmodule

// File: rtl/cic_mc_decim.sv
// Module: multichannel CIC decimator top.
// One sample per cycle at most, tagged with a channel. Results are registered
// and appear one cycle after the sample that completes a channel's D-block.
// Assumes in_ch < NCH whenever in_vld is high.
module cic_mc_decim #(
    parameter  int DW   = 12,
    parameter  int NCH  = 4,
    parameter  int NSTG = 3,
    parameter  int DEC  = 5,
    parameter  int DDLY = 2,
    localparam int CW   = cic_pkg::cic_ch_width(NCH),
    localparam int OW   = cic_pkg::cic_out_width(DW, NSTG, DEC, DDLY)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_vld,
    input  logic [CW-1:0] in_ch,
    input  logic [DW-1:0] in_data,
    input  logic          bypass,
    output logic          out_vld,
    output logic [CW-1:0] out_ch,
    output logic [OW-1:0] out_data
);
    localparam logic signed [OW-1:0] GAIN_V =
        OW'(cic_pkg::cic_gain(DEC, DDLY, NSTG));

    if (DEC < 2) begin : g_bad_dec
        $error("cic_mc_decim: DEC must be at least 2");
    end
    if (NSTG < 1 || DDLY < 1 || NCH < 1) begin : g_bad_par
        $error("cic_mc_decim: NSTG, DDLY and NCH must be positive");
    end

    logic          last;
    logic          flt_upd;
    logic          flt_fire;
    logic [OW-1:0] integ_sum;
    logic [OW-1:0] comb_out;
    logic [OW-1:0] byp_val;

    // Filtering state advances only for accepted, non-bypass samples.
    assign flt_upd  = in_vld && !bypass;
    assign flt_fire = flt_upd && last;

    // Debug path value: sign-extended sample times the DC gain.
    assign byp_val = $signed({{(OW - DW){in_data[DW-1]}}, in_data}) * GAIN_V;

    cic_phase_bank #(.NCH(NCH), .DEC(DEC), .CW(CW)) u_phase (
        .clk  (clk),
        .rst_n(rst_n),
        .adv  (in_vld),
        .ch   (in_ch),
        .last (last)
    );

    cic_integ_bank #(.NCH(NCH), .NSTG(NSTG), .DW(DW), .OW(OW), .CW(CW)) u_integ (
        .clk  (clk),
        .rst_n(rst_n),
        .upd  (flt_upd),
        .ch   (in_ch),
        .din  (in_data),
        .sum  (integ_sum)
    );

    cic_comb_bank #(.NCH(NCH), .NSTG(NSTG), .DDLY(DDLY), .OW(OW), .CW(CW)) u_comb (
        .clk  (clk),
        .rst_n(rst_n),
        .fire (flt_fire),
        .ch   (in_ch),
        .din  (integ_sum),
        .dout (comb_out)
    );

    // Register the result, its valid flag and its channel tag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld  <= 1'b0;
            out_ch   <= '0;
            out_data <= '0;
        end else begin
            out_vld <= in_vld && (bypass || last);
            if (in_vld) out_ch <= in_ch;
            if (in_vld && bypass) out_data <= last ? byp_val : '0;
            else if (flt_fire)    out_data <= comb_out;
        end
    end

    // Idle input cycles never produce a result.
    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> !out_vld);

    // Discarded positions produce no filtered result.
    assert_drop_pos_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && !bypass && !last) |=> !out_vld);

    // Kept positions always produce a result.
    assert_keep_pos_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && last) |=> out_vld);

    // Result tag follows the producing sample's channel.
    assert_tag_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> (out_ch == $past(in_ch)));

    // Zero-stuffed positions of the debug path are valid zeros.
    assert_stuff_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && bypass && !last) |=> (out_vld && out_data == '0));

endmodule

// File: tb/sim_cic_mc_decim.sv
// Bench: random and directed stimulus against a moving-sum cascade model.
module sim_cic_mc_decim;
    localparam int DW   = 12;
    localparam int NCH  = 4;
    localparam int NSTG = 3;
    localparam int DEC  = 5;
    localparam int DDLY = 2;
    localparam int DM   = DEC * DDLY;
    localparam int CW   = 2;
    localparam int OW   = DW + NSTG * $clog2(DM);
    localparam int MAXS = 400;
    localparam longint GAIN = longint'(DM) ** NSTG;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_vld = 1'b0;
    logic [CW-1:0] in_ch = '0;
    logic [DW-1:0] in_data = '0;
    logic          bypass = 1'b0;
    logic          out_vld;
    logic [CW-1:0] out_ch;
    logic [OW-1:0] out_data;

    int     n_chk = 0;
    int     n_bad = 0;
    longint hist[NCH][MAXS];
    int     nacc[NCH];
    int     rr = 0;

    always #10 clk = ~clk;

    cic_mc_decim #(.DW(DW), .NCH(NCH), .NSTG(NSTG), .DEC(DEC), .DDLY(DDLY)) u0 (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_ch(in_ch),
        .in_data(in_data), .bypass(bypass),
        .out_vld(out_vld), .out_ch(out_ch), .out_data(out_data)
    );

    // Cascade of NSTG moving sums of length D*M over a channel's history.
    function automatic longint cascade(int c, int n);
        longint s[MAXS];
        longint t[MAXS];
        for (int i = 0; i <= n; i++) s[i] = hist[c][i];
        for (int st = 0; st < NSTG; st++) begin
            for (int i = 0; i <= n; i++) begin
                longint a = 0;
                for (int j = 0; j < DM; j++) if (i - j >= 0) a += s[i-j];
                t[i] = a;
            end
            for (int i = 0; i <= n; i++) s[i] = t[i];
        end
        return s[n];
    endfunction

    function automatic longint rnd_sample();
        logic [DW-1:0] r = DW'($urandom);
        return longint'($signed(r));
    endfunction

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int c = 0; c < NCH; c++) nacc[c] = 0;
        rr = 0;
    endtask

    // Drive one cycle at a falling edge, then check the registered result.
    task automatic step(input logic v, input int c, input longint x, input logic b, input string req);
        logic   e_vld;
        longint e_val = 0;
        in_vld  = v;
        in_ch   = CW'(c);
        in_data = x[DW-1:0];
        bypass  = b;
        e_vld   = 1'b0;
        if (v) begin
            int k = nacc[c];
            nacc[c]++;
            if (b) begin
                e_vld = 1'b1;
                e_val = (k % DEC == DEC - 1) ? x * GAIN : 0;
            end else begin
                hist[c][k] = x;
                e_vld = (k % DEC == DEC - 1);
                if (e_vld) e_val = cascade(c, k);
            end
        end
        @(negedge clk);
        chk(v ? req : "R8", "out_vld", longint'(out_vld), longint'(e_vld));
        if (e_vld) begin
            chk("R5", "out_ch", longint'(out_ch), longint'(c));
            chk(req, "out_data", longint'($signed(out_data)), e_val);
        end
    endtask

    // Idle cycle with garbage on the data and channel pins (R2).
    task automatic idle(input string req);
        step(1'b0, int'($urandom % NCH), rnd_sample(), 1'($urandom), req);
    endtask

    task automatic do_reset();
        in_vld = 1'b0;
        rst_n  = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_clear();
        chk("R1", "out_vld after reset", longint'(out_vld), 0);
    endtask

    task automatic rr_sample(input longint x, input logic b, input string req);
        step(1'b1, rr, x, b, req);
        rr = (rr + 1) % NCH;
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240917));
        model_clear();
        @(negedge clk);
        do_reset();

        // R4: round-robin channels with random idle gaps and garbage (R2).
        for (int i = 0; i < 900; i++) begin
            if ($urandom % 4 == 0) idle("R2");
            else rr_sample(rnd_sample(), 1'b0, "R4");
        end

        // R5: channels in random order.
        for (int i = 0; i < 500; i++) begin
            if ($urandom % 5 == 0) idle("R2");
            else step(1'b1, int'($urandom % NCH), rnd_sample(), 1'b0, "R5");
        end

        // R1: reset mid-stream, then an impulse on channel 2 alone.
        do_reset();
        step(1'b1, 2, 700, 1'b0, "R1");
        for (int i = 0; i < 4 * DM; i++) step(1'b1, 2, 0, 1'b0, "R1");
        for (int i = 0; i < 2 * DEC * NCH; i++) rr_sample(0, 1'b0, "R1");

        // R6: full-scale negative then positive runs, exact results.
        do_reset();
        for (int i = 0; i < 12 * DEC * NCH; i++) rr_sample(-(longint'(1) << (DW - 1)), 1'b0, "R6");
        chk("R6", "negative full scale", longint'($signed(out_data)), -(longint'(1) << (DW - 1)) * GAIN);
        do_reset();
        for (int i = 0; i < 12 * DEC * NCH; i++) rr_sample((longint'(1) << (DW - 1)) - 1, 1'b0, "R6");
        chk("R6", "positive full scale", longint'($signed(out_data)), ((longint'(1) << (DW - 1)) - 1) * GAIN);

        // R7: debug path, with idle gaps.
        do_reset();
        for (int i = 0; i < 120; i++) begin
            if ($urandom % 6 == 0) idle("R8");
            else rr_sample(rnd_sample(), 1'b1, "R7");
        end
        in_vld = 1'b0;
        bypass = 1'b0;
        @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule